// File: doc/BRIEF.md
# Speculative Epoch Dependence Violation Detector

This block is the speculative-state part of one processor's private data cache in a chip where several processors run epochs of one program in parallel. Each local load or store carries the epoch number of the code that issued it. The block keeps a small direct-mapped line array in which every line holds a tag, a data word and three state bits: valid, read-speculatively and written-speculatively. Speculative stores stay in this array and reach the shared level only when software commits the epoch.

Stores by other processors arrive as invalidations that carry the writer's epoch number. The block treats a lower number as logically earlier. If an invalidation from an earlier epoch hits a line the local epoch has already read speculatively, the block has found a read-after-write violation. It raises a sticky interrupt, and software then squashes the local epoch.

A commit walks the array in ascending index order and emits one write-back per written-speculatively line. It then clears all speculative bits at once. A squash discards every written-speculatively line, clears all speculative bits and clears the interrupt in one cycle. An access that would evict a line still carrying speculative state is stalled and is not performed. Accesses are also stalled while a commit walk is running.

Top module: `spec_cache_ctrl`

## Requirements
- R1: After reset all lines are invalid, and `viol_irq`, `commit_busy`, `wb_valid` and `req_stall` are low.
- R2: An accepted load sets the read-speculative bit of its line. A later invalidation to the same address whose epoch is numerically lower (unsigned compare) than the epoch of the most recent accepted access raises `viol_irq` at the next clock edge.
- R3: An invalidation whose epoch is equal to or greater than the local epoch does not raise `viol_irq`.
- R4: An invalidation that hits no line, hits a different tag at the same index, or hits a line that is only written-speculatively does not raise `viol_irq`.
- R5: Once raised, `viol_irq` stays high until a squash.
- R6: `wb_valid` is never high outside a commit walk, so speculative stores are not visible at the write-back port before commit.
- R7: A `cmd_commit` pulse makes `commit_busy` high for exactly NUM_LINES cycles, starting at the next edge. In the cycle that visits index i, a written-speculatively line produces `wb_valid` with `wb_addr` = {tag, i} and the last stored word. Write-backs therefore come in ascending index order. After the walk no line is read-speculative.
- R8: A `cmd_squash` in any cycle clears `viol_irq` and `commit_busy` at the next edge, invalidates every written-speculatively line and clears all read-speculative bits. A squash takes priority over an access, an invalidation or a commit in the same cycle.
- R9: `req_stall` is high, and the request is not performed, when the request's index holds a valid speculative line with a different tag, or while `commit_busy` is high.
- R10: After a commit, a line that is no longer speculative no longer causes a stall, and an access with a different tag replaces it.
- R11: Address bits [IDX_W-1:0] select the line and the remaining upper bits form the tag. The defaults are 12-bit addresses, 8 lines, 16-bit data and 8-bit epochs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Store data |
| req_epoch | input | EPOCH_W | Epoch number of the issuing code |
| req_stall | output | 1 | Request not performed this cycle |
| inv_valid | input | 1 | Remote invalidation present |
| inv_addr | input | ADDR_W | Invalidated word address |
| inv_epoch | input | EPOCH_W | Epoch number of the remote writer |
| cmd_commit | input | 1 | Start the commit walk |
| cmd_squash | input | 1 | Discard speculative state |
| commit_busy | output | 1 | Commit walk in progress |
| wb_valid | output | 1 | Write-back word present |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| viol_irq | output | 1 | Sticky violation interrupt |

## Verification
The assertions assume that every input is driven to a known level from reset onward. They also assume that `cmd_commit` is only a request, so the block decides whether it takes effect. The stimulus changes inputs only at falling clock edges and drives every control line low when it is idle. It therefore never relies on an unknown value or on a race at the sampling edge. Store sequences use distinct indices or repeat the same address, so the bench's shadow of the written lines stays exact and no access is stalled unless a test intends the stall.

// File: rtl/spc_pkg.sv
// Package: shared types for the speculative cache controller.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package spc_pkg;

    // Per-line state bits.
    typedef struct packed {
        logic valid;
        logic rd_spec;
        logic wr_spec;
    } line_state_t;

    // Commit walk phases.
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_SCAN = 1'b1
    } walk_state_t;

endpackage

// File: rtl/spc_line_array.sv
// Module: spc_line_array
// Holds tag, data and speculative state for each direct-mapped line. It applies,
// in priority order: squash flash, commit flash, local access, clean-line drop.
// Assumes: at most one access and one drop per cycle. The caller has already
// refused accesses that would evict a speculative line.
module spc_line_array
    import spc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 9,
    parameter int DATA_W    = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_en,
    input  logic                              acc_write,
    input  logic [IDX_W-1:0]                  acc_idx,
    input  logic [TAG_W-1:0]                  acc_tag,
    input  logic [DATA_W-1:0]                 acc_data,
    input  logic                              drop_en,
    input  logic [IDX_W-1:0]                  drop_idx,
    input  logic                              flash_commit,
    input  logic                              flash_squash,
    output line_state_t [NUM_LINES-1:0]       st_o,
    output logic [NUM_LINES-1:0][TAG_W-1:0]   tag_o,
    output logic [NUM_LINES-1:0][DATA_W-1:0]  data_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        line_state_t       st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;
        logic              acc_here;
        logic              hit_here;

        // Purpose: decode whether this line is addressed and holds the tag.
        always_comb begin
            acc_here = acc_en && (acc_idx == MY_IDX);
            hit_here = st_q.valid && (tag_q == acc_tag);
        end

        // Purpose: update one line's tag, data and speculative bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= '0;
                tag_q  <= '0;
                data_q <= '0;
            end else if (flash_squash) begin
                if (st_q.wr_spec) begin
                    st_q.valid <= 1'b0;
                end
                st_q.rd_spec <= 1'b0;
                st_q.wr_spec <= 1'b0;
            end else if (flash_commit) begin
                st_q.rd_spec <= 1'b0;
                st_q.wr_spec <= 1'b0;
            end else if (acc_here) begin
                if (hit_here) begin
                    if (acc_write) begin
                        st_q.wr_spec <= 1'b1;
                        data_q       <= acc_data;
                    end else begin
                        st_q.rd_spec <= 1'b1;
                    end
                end else begin
                    st_q.valid   <= 1'b1;
                    st_q.rd_spec <= !acc_write;
                    st_q.wr_spec <= acc_write;
                    tag_q        <= acc_tag;
                    data_q       <= acc_write ? acc_data : '0;
                end
            end else if (drop_en && (drop_idx == MY_IDX)) begin
                st_q.valid <= 1'b0;
            end
        end

        assign st_o[i]   = st_q;
        assign tag_o[i]  = tag_q;
        assign data_o[i] = data_q;
    end

endmodule

// File: rtl/spc_viol_detect.sv
// Module: spc_viol_detect
// Checks each remote invalidation against the local speculative state. It raises
// a sticky violation when an earlier epoch hits a read-speculative line, and
// asks for clean lines to be dropped.
// Assumes: epoch numbers compare as plain unsigned values (no wrap).
module spc_viol_detect
    import spc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 9,
    parameter int EPOCH_W   = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inv_valid,
    input  logic [IDX_W-1:0]                 inv_idx,
    input  logic [TAG_W-1:0]                 inv_tag,
    input  logic [EPOCH_W-1:0]               inv_epoch,
    input  logic [EPOCH_W-1:0]               local_epoch,
    input  line_state_t [NUM_LINES-1:0]      st_i,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_i,
    input  logic                             squash,
    output logic                             drop_en,
    output logic                             viol_o
);

    line_state_t sel_st;
    logic        inv_hit;
    logic        earlier;
    logic        viol_set;
    logic        viol_q;

    // Purpose: look up the invalidated line and compare the epochs.
    always_comb begin
        sel_st   = st_i[inv_idx];
        inv_hit  = inv_valid && sel_st.valid && (tag_i[inv_idx] == inv_tag);
        earlier  = inv_epoch < local_epoch;
        viol_set = inv_hit && sel_st.rd_spec && earlier;
        drop_en  = inv_hit && !sel_st.rd_spec && !sel_st.wr_spec;
    end

    // Purpose: hold the violation until software squashes the epoch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (squash) begin
            viol_q <= 1'b0;
        end else if (viol_set) begin
            viol_q <= 1'b1;
        end
    end

    assign viol_o = viol_q;

endmodule

// File: rtl/spc_commit_seq.sv
// Module: spc_commit_seq
// Walks every line index once per commit, one index per cycle in ascending
// order. It flags the write-back of written-speculative lines and flashes the
// speculative bits clear at the end of the walk.
// Assumes: squash may arrive at any time and aborts the walk.
module spc_commit_seq
    import spc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  squash,
    input  logic [NUM_LINES-1:0]  wr_spec_v,
    output logic                  busy,
    output logic [IDX_W-1:0]      scan_idx,
    output logic                  wb_fire,
    output logic                  flash_commit
);

    walk_state_t      state_q;
    logic [IDX_W-1:0] idx_q;

    // Purpose: advance the walk state and the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
        end else if (squash) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (start) begin
                        state_q <= WALK_SCAN;
                        idx_q   <= '0;
                    end
                end
                WALK_SCAN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= WALK_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // Purpose: decode the write-back strobe and the end-of-walk flash.
    always_comb begin
        busy         = (state_q == WALK_SCAN);
        scan_idx     = idx_q;
        wb_fire      = busy && wr_spec_v[idx_q];
        flash_commit = busy && (idx_q == LAST_IDX) && !squash;
    end

endmodule

// File: rtl/spec_cache_ctrl.sv
// Module: spec_cache_ctrl (top)
// Speculative data cache controller for one processor. It tracks lines read
// and written speculatively, detects read-after-write violations from remote
// invalidations, buffers stores until commit and discards them on squash.
// Assumes: NUM_LINES is a power of two. The epoch register follows the latest
// accepted access.
module spec_cache_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int EPOCH_W   = 8,
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [EPOCH_W-1:0] req_epoch,
    output logic               req_stall,
    input  logic               inv_valid,
    input  logic [ADDR_W-1:0]  inv_addr,
    input  logic [EPOCH_W-1:0] inv_epoch,
    input  logic               cmd_commit,
    input  logic               cmd_squash,
    output logic               commit_busy,
    output logic               wb_valid,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [DATA_W-1:0]  wb_data,
    output logic               viol_irq
);

    line_state_t [NUM_LINES-1:0]      st;
    logic [NUM_LINES-1:0][TAG_W-1:0]  tags;
    logic [NUM_LINES-1:0][DATA_W-1:0] data;
    logic [NUM_LINES-1:0]             wr_spec_v;

    logic [IDX_W-1:0]   req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [IDX_W-1:0]   inv_idx;
    logic [TAG_W-1:0]   inv_tag;
    line_state_t        req_line;
    logic               conflict;
    logic               acc_en;
    logic               drop_en;
    logic               flash_commit;
    logic               wb_fire;
    logic [IDX_W-1:0]   scan_idx;
    logic [EPOCH_W-1:0] epoch_q;

    // Purpose: split the addresses into index and tag fields.
    always_comb begin
        req_idx = req_addr[IDX_W-1:0];
        req_tag = req_addr[ADDR_W-1:IDX_W];
        inv_idx = inv_addr[IDX_W-1:0];
        inv_tag = inv_addr[ADDR_W-1:IDX_W];
    end

    // Purpose: gather the written-speculative bits for the commit walk.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            wr_spec_v[i] = st[i].wr_spec;
        end
    end

    // Purpose: refuse accesses that would evict speculative state or race a walk.
    always_comb begin
        req_line  = st[req_idx];
        conflict  = req_line.valid && (req_line.rd_spec || req_line.wr_spec)
                    && (tags[req_idx] != req_tag);
        req_stall = req_valid && (commit_busy || conflict);
        acc_en    = req_valid && !req_stall && !cmd_squash;
    end

    // Purpose: remember the epoch number of the latest accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epoch_q <= '0;
        end else if (acc_en) begin
            epoch_q <= req_epoch;
        end
    end

    spc_line_array #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_en       (acc_en),
        .acc_write    (req_write),
        .acc_idx      (req_idx),
        .acc_tag      (req_tag),
        .acc_data     (req_wdata),
        .drop_en      (drop_en),
        .drop_idx     (inv_idx),
        .flash_commit (flash_commit),
        .flash_squash (cmd_squash),
        .st_o         (st),
        .tag_o        (tags),
        .data_o       (data)
    );

    spc_viol_detect #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .EPOCH_W   (EPOCH_W)
    ) u_viol (
        .clk         (clk),
        .rst_n       (rst_n),
        .inv_valid   (inv_valid),
        .inv_idx     (inv_idx),
        .inv_tag     (inv_tag),
        .inv_epoch   (inv_epoch),
        .local_epoch (epoch_q),
        .st_i        (st),
        .tag_i       (tags),
        .squash      (cmd_squash),
        .drop_en     (drop_en),
        .viol_o      (viol_irq)
    );

    spc_commit_seq #(
        .NUM_LINES (NUM_LINES)
    ) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cmd_commit),
        .squash       (cmd_squash),
        .wr_spec_v    (wr_spec_v),
        .busy         (commit_busy),
        .scan_idx     (scan_idx),
        .wb_fire      (wb_fire),
        .flash_commit (flash_commit)
    );

    // Purpose: present the visited line at the write-back port.
    always_comb begin
        wb_valid = wb_fire;
        wb_addr  = {tags[scan_idx], scan_idx};
        wb_data  = data[scan_idx];
    end

endmodule

// File: rtl/spec_cache_ctrl_chk.sv
// Module: spec_cache_ctrl_chk
// Port-level temporal checks for spec_cache_ctrl, attached by bind.
// Assumes: all inputs are known from reset onward.
module spec_cache_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_stall,
    input logic inv_valid,
    input logic cmd_commit,
    input logic cmd_squash,
    input logic commit_busy,
    input logic wb_valid,
    input logic viol_irq
);

    a_r6_wb_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> commit_busy);

    a_r5_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_irq && !cmd_squash) |=> viol_irq);

    a_r8_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_squash |=> (!viol_irq && !commit_busy));

    a_r9_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_busy && req_valid) |-> req_stall);

    a_r2_viol_needs_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_irq && !cmd_squash && !inv_valid) |=> !viol_irq);

    a_r7_walk_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_commit && !commit_busy && !cmd_squash) |=> commit_busy);

    a_r9_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_stall);

endmodule

bind spec_cache_ctrl spec_cache_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_stall   (req_stall),
    .inv_valid   (inv_valid),
    .cmd_commit  (cmd_commit),
    .cmd_squash  (cmd_squash),
    .commit_busy (commit_busy),
    .wb_valid    (wb_valid),
    .viol_irq    (viol_irq)
);

// File: tb/test_spec_cache_ctrl.sv
// Bench for spec_cache_ctrl: a vector table of violation scenarios, then
// directed tests of reset, commit order, stalls and squash.
module test_spec_cache_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    localparam logic [1:0] OP_LD = 2'd0;
    localparam logic [1:0] OP_ST = 2'd1;
    localparam logic [1:0] OP_IV = 2'd2;
    localparam logic [1:0] OP_SQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [15:0] data;
        logic [7:0]  ep;
        logic        exp_viol;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{OP_LD, 12'h010, 16'h0000, 8'd5,   1'b0},  // R2 load marks line
        '{OP_IV, 12'h010, 16'h0000, 8'd7,   1'b0},  // R3 later epoch
        '{OP_IV, 12'h010, 16'h0000, 8'd5,   1'b0},  // R3 equal epoch
        '{OP_IV, 12'h018, 16'h0000, 8'd2,   1'b0},  // R4 other tag
        '{OP_IV, 12'h010, 16'h0000, 8'd2,   1'b1},  // R2 violation
        '{OP_IV, 12'h020, 16'h0000, 8'd9,   1'b1},  // R5 sticky
        '{OP_SQ, 12'h000, 16'h0000, 8'd0,   1'b0},  // R8 clear
        '{OP_ST, 12'h021, 16'h1234, 8'd6,   1'b0},
        '{OP_IV, 12'h021, 16'h0000, 8'd1,   1'b0},  // R4 store only
        '{OP_LD, 12'h021, 16'h0000, 8'd6,   1'b0},
        '{OP_IV, 12'h021, 16'h0000, 8'd1,   1'b1},  // R2
        '{OP_SQ, 12'h000, 16'h0000, 8'd0,   1'b0},  // R8
        '{OP_LD, 12'h033, 16'h0000, 8'd200, 1'b0},
        '{OP_IV, 12'h033, 16'h0000, 8'd100, 1'b1},  // R2 unsigned
        '{OP_SQ, 12'h000, 16'h0000, 8'd0,   1'b0},  // R8
        '{OP_IV, 12'h010, 16'h0000, 8'd0,   1'b0}   // R8 bits cleared
    };

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [11:0] req_addr;
    logic [15:0] req_wdata;
    logic [7:0]  req_epoch;
    logic        req_stall;
    logic        inv_valid;
    logic [11:0] inv_addr;
    logic [7:0]  inv_epoch;
    logic        cmd_commit;
    logic        cmd_squash;
    logic        commit_busy;
    logic        wb_valid;
    logic [11:0] wb_addr;
    logic [15:0] wb_data;
    logic        viol_irq;

    int n_chk  = 0;
    int n_fail = 0;

    // Shadow of written-speculative lines.
    logic        m_sm   [NL];
    logic [11:0] m_addr [NL];
    logic [15:0] m_data [NL];

    spec_cache_ctrl i_spec_cache_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_epoch   (req_epoch),
        .req_stall   (req_stall),
        .inv_valid   (inv_valid),
        .inv_addr    (inv_addr),
        .inv_epoch   (inv_epoch),
        .cmd_commit  (cmd_commit),
        .cmd_squash  (cmd_squash),
        .commit_busy (commit_busy),
        .wb_valid    (wb_valid),
        .wb_addr     (wb_addr),
        .wb_data     (wb_data),
        .viol_irq    (viol_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_addr   = '0;
        req_wdata  = '0;
        req_epoch  = '0;
        inv_valid  = 1'b0;
        inv_addr   = '0;
        inv_epoch  = '0;
        cmd_commit = 1'b0;
        cmd_squash = 1'b0;
    endtask

    // Starts just after a falling edge, spans one rising edge.
    task automatic do_op(input logic [1:0] op, input logic [11:0] addr,
                         input logic [15:0] data, input logic [7:0] ep);
        case (op)
            OP_LD, OP_ST: begin
                req_valid = 1'b1;
                req_write = (op == OP_ST);
                req_addr  = addr;
                req_wdata = data;
                req_epoch = ep;
                if (op == OP_ST) begin
                    m_sm[addr[2:0]]   = 1'b1;
                    m_addr[addr[2:0]] = addr;
                    m_data[addr[2:0]] = data;
                end
            end
            OP_IV: begin
                inv_valid = 1'b1;
                inv_addr  = addr;
                inv_epoch = ep;
            end
            default: begin
                cmd_squash = 1'b1;
                for (int i = 0; i < NL; i++) m_sm[i] = 1'b0;
            end
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    // Commit walk: checks length, order and content against the shadow.
    task automatic do_commit(input string req, input logic probe);
        int exp_idx [NL];
        int n_exp = 0;
        int n_got = 0;
        int cyc = 0;
        for (int i = 0; i < NL; i++) begin
            if (m_sm[i]) begin
                exp_idx[n_exp] = i;
                n_exp++;
            end
        end
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
        while (commit_busy && cyc < 20) begin
            if (probe && cyc == 0) begin
                req_valid = 1'b1;
                req_write = 1'b0;
                req_addr  = 12'h0F0;
                req_epoch = 8'd10;
                #1;
                check("R9 stall during walk", 32'(req_stall), 32'd1);
            end
            if (wb_valid) begin
                if (n_got < n_exp) begin
                    check({req, " wb addr"}, 32'(wb_addr), 32'(m_addr[exp_idx[n_got]]));
                    check({req, " wb data"}, 32'(wb_data), 32'(m_data[exp_idx[n_got]]));
                end
                n_got++;
            end
            cyc++;
            @(negedge clk);
            idle_inputs();
        end
        check({req, " walk length"}, 32'(cyc), 32'(NL));
        check({req, " wb count"}, 32'(n_got), 32'(n_exp));
        for (int i = 0; i < NL; i++) m_sm[i] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_sm[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0;
        end
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 viol_irq", 32'(viol_irq), 32'd0);
        check("R1 commit_busy", 32'(commit_busy), 32'd0);
        check("R1 wb_valid", 32'(wb_valid), 32'd0);
        check("R1 req_stall", 32'(req_stall), 32'd0);

        // Table of violation scenarios (R2 R3 R4 R5 R8, R11 mapping)
        for (int v = 0; v < NV; v++) begin
            do_op(TBL[v].op, TBL[v].addr, TBL[v].data, TBL[v].ep);
            check($sformatf("R2/R3/R4/R5/R8 vector %0d viol", v),
                  32'(viol_irq), 32'(TBL[v].exp_viol));
        end

        // R6 R7 commit order and content
        do_op(OP_ST, 12'h045, 16'hA001, 8'd10);
        check("R6 hidden store", 32'(wb_valid), 32'd0);
        do_op(OP_ST, 12'h012, 16'hB002, 8'd10);
        do_op(OP_ST, 12'h012, 16'hC003, 8'd10);
        check("R6 hidden store", 32'(wb_valid), 32'd0);
        do_op(OP_LD, 12'h013, 16'h0000, 8'd10);
        do_op(OP_ST, 12'h047, 16'hD004, 8'd10);
        check("R6 hidden store", 32'(wb_valid), 32'd0);
        do_commit("R7 commit", 1'b0);
        do_op(OP_IV, 12'h013, 16'h0000, 8'd0);
        check("R7 read bits cleared", 32'(viol_irq), 32'd0);

        // R9 conflict stall, R10 no stall after commit
        do_op(OP_LD, 12'h061, 16'h0000, 8'd10);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h069;
        req_wdata = 16'hEEEE; req_epoch = 8'd10;
        #1;
        check("R9 conflict stall", 32'(req_stall), 32'd1);
        @(negedge clk);
        idle_inputs();
        do_commit("R9 stalled store dropped", 1'b0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h069; req_epoch = 8'd10;
        #1;
        check("R10 no stall after commit", 32'(req_stall), 32'd0);
        idle_inputs();
        do_op(OP_ST, 12'h069, 16'h5A5A, 8'd10);
        do_commit("R10 replaced line written back", 1'b0);

        // R9 stall during walk
        do_op(OP_ST, 12'h075, 16'h7777, 8'd10);
        do_commit("R9 walk with probe", 1'b1);

        // R8 squash discards stores
        do_op(OP_ST, 12'h044, 16'h4444, 8'd10);
        do_op(OP_SQ, 12'h000, 16'h0000, 8'd0);
        do_commit("R8 squash discards", 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule